// File: doc/BRIEF.md
# Decode-Stage Branch Resolver and Next-PC Unit

This block sits beside the decode stage of a five-stage in-order pipeline. It holds the fetch program counter and picks the next one every cycle. Fetch runs sequentially by default, which amounts to predicting every branch not taken. When a conditional branch reaches decode, the block does two things in that stage. It compares the branch source register against zero, and it adds the scaled offset to the branch's PC+4 with an adder of its own. Because the outcome is known in decode, a taken branch costs one cycle, and a not-taken branch costs none.

The pipeline can run in one of three behaviours. In the plain behaviour, a taken branch kills the single instruction that was fetched behind it. In the two canceling behaviours, that instruction is a delay slot. It runs when the branch goes the predicted way and is nullified when the branch goes the other way. The prediction comes either from a hint bit in the encoding or from the sign of the offset, where backward means taken. If the instruction in execute is about to write the branch's source register, decode stalls one cycle. A redirect from a later stage overrides a stall and any branch in decode.

Top module: `brc_next_pc`

## Requirements
- R1: While reset is held, `fetch_pc` equals the parameter RESET_PC (default 0x0000_0100).
- R2: When there is no redirect, no stall and no taken branch, `next_pc` is `fetch_pc`+4, and `fetch_pc` takes that value at the next clock edge.
- R3: A branch in decode resolves taken when the source value is zero and `id_cond_ne`=0, or when the source value is nonzero and `id_cond_ne`=1. `br_taken` reports this outcome.
- R4: The taken target is `id_pc_plus4` plus the sign-extended 16-bit `id_offset` shifted left by two. A taken branch drives this target on `next_pc`.
- R5: With `mode`=2'b00 or 2'b11 (plain), a taken branch raises `flush_if` and never raises `nullify_slot`. A not-taken branch raises neither signal and lets fetch continue at `fetch_pc`+4.
- R6: With `mode`=2'b01 (hint canceling), the prediction is `id_hint` (1 = taken). `nullify_slot` rises exactly when the outcome differs from the prediction. `flush_if` stays low for the branch.
- R7: With `mode`=2'b10 (direction canceling), the prediction is bit 15 of `id_offset`, so a backward branch is predicted taken. Nullification then follows the rule of R6.
- R8: If a valid branch in decode reads register `id_rs` while `ex_wr_en`=1 and `ex_rd`=`id_rs`, then `stall_id` rises and `next_pc` holds `fetch_pc`. In that cycle `br_taken`, `flush_if` and `nullify_slot` are all low.
- R9: `redirect` takes priority over everything else. When it is high, `next_pc` is `redirect_pc`, `flush_if` is high, and `stall_id`, `br_taken` and `nullify_slot` are low.
- R10: When `id_valid` is low, or when `id_is_branch` is low, the branch fields have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00/11 plain, 01 hint canceling, 10 direction canceling |
| redirect | input | 1 | Later-stage redirect request |
| redirect_pc | input | 32 | Redirect destination |
| id_valid | input | 1 | Decode holds a valid instruction |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_cond_ne | input | 1 | 0: taken on zero, 1: taken on nonzero |
| id_hint | input | 1 | Encoded predicted direction (1 = taken) |
| id_offset | input | 16 | Word offset of the branch |
| id_rs | input | 5 | Branch source register index |
| id_rs_val | input | 32 | Branch source register value |
| id_pc_plus4 | input | 32 | PC+4 of the branch instruction |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_rd | input | 5 | Destination index of the execute instruction |
| fetch_pc | output | 32 | Current fetch address |
| next_pc | output | 32 | Fetch address for the next cycle |
| br_taken | output | 1 | Branch in decode resolved taken |
| flush_if | output | 1 | Kill the instruction in fetch |
| nullify_slot | output | 1 | Turn the delay-slot instruction into a no-op |
| stall_id | output | 1 | Hold decode and fetch one cycle |

## Verification
The bench creates cycles in which two decisions coincide. In one, a branch waits on an execute-stage write while a redirect arrives. In another, a taken branch resolves while a redirect arrives. The redirect must win in both: `stall_id` is low, `flush_if` is high and the fetch address moves to `redirect_pc`. The bench also checks the cycle after a stall. There the same branch resolves normally, and in canceling modes the correct/incorrect prediction must nullify the slot or keep it, with no flush.

// File: rtl/brc_pkg.sv
package brc_pkg;
   localparam logic [1:0] MODE_PLAIN  = 2'b00;
   localparam logic [1:0] MODE_HINT   = 2'b01;
   localparam logic [1:0] MODE_DIR    = 2'b10;
   localparam logic [1:0] MODE_PLAIN2 = 2'b11;

   typedef enum logic [1:0] {
      SEL_SEQ,
      SEL_HOLD,
      SEL_TARGET,
      SEL_REDIR
   } pc_sel_e;
endpackage

// File: rtl/brc_zero_test.sv
module brc_zero_test #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] val,
   input  logic            sense_ne,
   output logic            cond_true
);
   logic is_zero;

   assign is_zero   = (val == '0);
   assign cond_true = is_zero ^ sense_ne;
endmodule

// File: rtl/brc_target_adder.sv
module brc_target_adder #(
   parameter int XLEN  = 32,
   parameter int OFF_W = 16,
   parameter int SHIFT = 2
) (
   input  logic [XLEN-1:0]  base,
   input  logic [OFF_W-1:0] offset,
   output logic [XLEN-1:0]  target
);
   localparam int EXT_W = XLEN - OFF_W - SHIFT;

   logic [XLEN-1:0] scaled;

   generate
      if (EXT_W < 0) begin : g_bad_width
         $error("brc_target_adder: XLEN too small for OFF_W+SHIFT");
      end
      if (SHIFT == 0) begin : g_noshift
         assign scaled = {{EXT_W{offset[OFF_W-1]}}, offset};
      end else begin : g_shift
         assign scaled = {{EXT_W{offset[OFF_W-1]}}, offset, {SHIFT{1'b0}}};
      end
   endgenerate

   assign target = base + scaled;
endmodule

// File: rtl/brc_hazard_detect.sv
module brc_hazard_detect #(
   parameter int REG_AW = 5
) (
   input  logic              reads_rs,
   input  logic [REG_AW-1:0] rs,
   input  logic              ex_wr_en,
   input  logic [REG_AW-1:0] ex_rd,
   output logic              hazard
);
   assign hazard = reads_rs && ex_wr_en && (ex_rd == rs);
endmodule

// File: rtl/brc_next_pc.sv
module brc_next_pc
   import brc_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter int          OFF_W    = 16,
   parameter int          REG_AW   = 5,
   parameter int          SHIFT    = 2,
   parameter logic [31:0] RESET_PC = 32'h0000_0100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              redirect,
   input  logic [XLEN-1:0]   redirect_pc,
   input  logic              id_valid,
   input  logic              id_is_branch,
   input  logic              id_cond_ne,
   input  logic              id_hint,
   input  logic [OFF_W-1:0]  id_offset,
   input  logic [REG_AW-1:0] id_rs,
   input  logic [XLEN-1:0]   id_rs_val,
   input  logic [XLEN-1:0]   id_pc_plus4,
   input  logic              ex_wr_en,
   input  logic [REG_AW-1:0] ex_rd,
   output logic [XLEN-1:0]   fetch_pc,
   output logic [XLEN-1:0]   next_pc,
   output logic              br_taken,
   output logic              flush_if,
   output logic              nullify_slot,
   output logic              stall_id
);
   localparam logic [XLEN-1:0] SEQ_STEP = XLEN'(1 << SHIFT);

   generate
      if (XLEN > 32 || XLEN < OFF_W + SHIFT) begin : g_chk_xlen
         $error("brc_next_pc: XLEN out of range");
      end
      if (REG_AW < 1) begin : g_chk_aw
         $error("brc_next_pc: REG_AW must be positive");
      end
   endgenerate

   logic            br_in_id;
   logic            cond_true;
   logic            hazard;
   logic            br_active;
   logic            cancel_mode;
   logic            pred_taken;
   logic [XLEN-1:0] target;
   pc_sel_e         sel;

   assign br_in_id = id_valid && id_is_branch;

   brc_zero_test #(.XLEN(XLEN)) u_zero (
      .val       (id_rs_val),
      .sense_ne  (id_cond_ne),
      .cond_true (cond_true)
   );

   brc_target_adder #(.XLEN(XLEN), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_tgt (
      .base   (id_pc_plus4),
      .offset (id_offset),
      .target (target)
   );

   brc_hazard_detect #(.REG_AW(REG_AW)) u_haz (
      .reads_rs (br_in_id),
      .rs       (id_rs),
      .ex_wr_en (ex_wr_en),
      .ex_rd    (ex_rd),
      .hazard   (hazard)
   );

   always_comb begin
      cancel_mode = 1'b0;
      pred_taken  = 1'b0;
      unique case (mode)
         MODE_HINT: begin
            cancel_mode = 1'b1;
            pred_taken  = id_hint;
         end
         MODE_DIR: begin
            cancel_mode = 1'b1;
            pred_taken  = id_offset[OFF_W-1];
         end
         default: begin
            cancel_mode = 1'b0;
            pred_taken  = 1'b0;
         end
      endcase
   end

   assign br_active    = br_in_id && !hazard && !redirect;
   assign stall_id     = br_in_id && hazard && !redirect;
   assign br_taken     = br_active && cond_true;
   assign flush_if     = redirect || (br_taken && !cancel_mode);
   assign nullify_slot = br_active && cancel_mode && (cond_true != pred_taken);

   always_comb begin
      if (redirect)      sel = SEL_REDIR;
      else if (stall_id) sel = SEL_HOLD;
      else if (br_taken) sel = SEL_TARGET;
      else               sel = SEL_SEQ;
   end

   always_comb begin
      unique case (sel)
         SEL_REDIR:  next_pc = redirect_pc;
         SEL_HOLD:   next_pc = fetch_pc;
         SEL_TARGET: next_pc = target;
         default:    next_pc = fetch_pc + SEQ_STEP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) fetch_pc <= RESET_PC[XLEN-1:0];
      else        fetch_pc <= next_pc;
   end

   AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      stall_id |-> (!flush_if && !nullify_slot && !br_taken)); // R8
   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      stall_id |=> (fetch_pc == $past(fetch_pc))); // R8
   AST_REDIRECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> (!stall_id && flush_if && !nullify_slot)); // R9
   AST_REDIRECT_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> (fetch_pc == $past(redirect_pc))); // R9
   AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (!redirect && !stall_id && !br_taken) |=> (fetch_pc == $past(fetch_pc) + SEQ_STEP)); // R2
   AST_PLAIN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (br_taken && !mode[0] && !mode[1]) |-> (flush_if && !nullify_slot)); // R5
   AST_CANCEL_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (!redirect && (mode == MODE_HINT || mode == MODE_DIR)) |-> !flush_if); // R6
   AST_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!id_valid || !id_is_branch) |-> (!br_taken && !stall_id && !nullify_slot)); // R10
endmodule

// File: tb/brc_next_pc_tb.sv
module brc_next_pc_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        redirect = 1'b0;
   logic [31:0] redirect_pc = '0;
   logic        id_valid = 1'b0;
   logic        id_is_branch = 1'b0;
   logic        id_cond_ne = 1'b0;
   logic        id_hint = 1'b0;
   logic [15:0] id_offset = '0;
   logic [4:0]  id_rs = '0;
   logic [31:0] id_rs_val = '0;
   logic [31:0] id_pc_plus4 = '0;
   logic        ex_wr_en = 1'b0;
   logic [4:0]  ex_rd = '0;
   logic [31:0] fetch_pc, next_pc;
   logic        br_taken, flush_if, nullify_slot, stall_id;

   int checks = 0;
   int fails = 0;
   logic [31:0] exp_pc = 32'h0000_0100;

   typedef struct {
      logic [31:0] pc;
      logic [31:0] npc;
      logic        tk;
      logic        fl;
      logic        nu;
      logic        st;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #5 clk = ~clk;

   brc_next_pc u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .redirect(redirect), .redirect_pc(redirect_pc),
      .id_valid(id_valid), .id_is_branch(id_is_branch), .id_cond_ne(id_cond_ne),
      .id_hint(id_hint), .id_offset(id_offset), .id_rs(id_rs), .id_rs_val(id_rs_val),
      .id_pc_plus4(id_pc_plus4), .ex_wr_en(ex_wr_en), .ex_rd(ex_rd),
      .fetch_pc(fetch_pc), .next_pc(next_pc), .br_taken(br_taken), .flush_if(flush_if),
      .nullify_slot(nullify_slot), .stall_id(stall_id)
   );

   task automatic check(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // Driver: applies one decode-stage picture, predicts outputs, waits one cycle
   task automatic drive(input logic [1:0] md, input logic rd, input logic [31:0] rpc,
                        input logic v, input logic br, input logic ne, input logic hn,
                        input logic [15:0] off, input logic [4:0] rs, input logic [31:0] rv,
                        input logic [31:0] p4, input logic xw, input logic [4:0] xr,
                        input string tag);
      exp_t e;
      logic haz, act, cond, cancel, pred;
      logic [31:0] tgt;
      mode = md; redirect = rd; redirect_pc = rpc; id_valid = v; id_is_branch = br;
      id_cond_ne = ne; id_hint = hn; id_offset = off; id_rs = rs; id_rs_val = rv;
      id_pc_plus4 = p4; ex_wr_en = xw; ex_rd = xr;
      haz    = v && br && xw && (xr == rs);
      act    = v && br && !rd && !haz;
      cond   = ((rv == 0) && !ne) || ((rv != 0) && ne);
      tgt    = p4 + {{14{off[15]}}, off, 2'b00};
      cancel = (md == 2'b01) || (md == 2'b10);
      pred   = (md == 2'b01) ? hn : (md == 2'b10) ? off[15] : 1'b0;
      e.pc  = exp_pc;
      e.st  = haz && !rd;
      e.tk  = act && cond;
      e.fl  = rd || (e.tk && !cancel);
      e.nu  = act && cancel && (cond != pred);
      e.npc = rd ? rpc : e.st ? exp_pc : e.tk ? tgt : exp_pc + 32'd4;
      e.tag = tag;
      sb.push_back(e);
      exp_pc = e.npc;
      @(posedge clk);
      #2;
   endtask

   // Monitor: compares at the falling edge, away from the active edge
   always @(negedge clk) begin
      if (rst_n && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(e.tag, "fetch_pc", fetch_pc, e.pc);
         check(e.tag, "next_pc", next_pc, e.npc);
         check(e.tag, "br_taken", {31'd0, br_taken}, {31'd0, e.tk});
         check(e.tag, "flush_if", {31'd0, flush_if}, {31'd0, e.fl});
         check(e.tag, "nullify_slot", {31'd0, nullify_slot}, {31'd0, e.nu});
         check(e.tag, "stall_id", {31'd0, stall_id}, {31'd0, e.st});
      end
   end

   initial begin
      #200000;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_up();
   end

   initial begin
      repeat (3) @(posedge clk);
      #3;
      check("R1", "fetch_pc in reset", fetch_pc, 32'h0000_0100);
      @(posedge clk);
      #2;
      check("R1", "fetch_pc in reset", fetch_pc, 32'h0000_0100);
      rst_n = 1'b1;
      //     mode  rd  rpc          v  br ne hn off       rs  rval         pc+4         xw xr
      drive(2'b00, 0, 32'h0,       0, 0, 0, 0, 16'h0000, 5'd0, 32'h0,       32'h0,       0, 5'd0, "R2");
      drive(2'b00, 0, 32'h0,       0, 0, 0, 0, 16'h0000, 5'd0, 32'h0,       32'h0,       0, 5'd0, "R2");
      drive(2'b00, 0, 32'h0,       1, 1, 0, 0, 16'h0010, 5'd3, 32'h0,       32'h0000_0200, 0, 5'd0, "R5_taken_R4");
      drive(2'b00, 0, 32'h0,       1, 1, 0, 0, 16'h0010, 5'd3, 32'h0000_0007, 32'h0000_0244, 0, 5'd0, "R5_not_taken");
      drive(2'b00, 0, 32'h0,       1, 1, 1, 0, 16'h0004, 5'd4, 32'h8000_0000, 32'h0000_0300, 0, 5'd0, "R3_ne");
      drive(2'b00, 0, 32'h0,       1, 1, 1, 0, 16'h0004, 5'd4, 32'h0,       32'h0000_0300, 0, 5'd0, "R3_ne_zero");
      drive(2'b00, 0, 32'h0,       1, 1, 0, 0, 16'hFFF0, 5'd5, 32'h0,       32'h0000_1000, 0, 5'd0, "R4_backward");
      drive(2'b00, 0, 32'h0,       1, 1, 0, 0, 16'h0008, 5'd6, 32'h0,       32'h0000_0400, 1, 5'd6, "R8_stall");
      drive(2'b00, 0, 32'h0,       1, 1, 0, 0, 16'h0008, 5'd6, 32'h0,       32'h0000_0400, 1, 5'd7, "R8_after");
      drive(2'b01, 0, 32'h0,       1, 1, 0, 1, 16'h0020, 5'd2, 32'h0,       32'h0000_0500, 0, 5'd0, "R6_hit_taken");
      drive(2'b01, 0, 32'h0,       1, 1, 0, 0, 16'h0020, 5'd2, 32'h0,       32'h0000_0500, 0, 5'd0, "R6_miss_taken");
      drive(2'b01, 0, 32'h0,       1, 1, 0, 1, 16'h0020, 5'd2, 32'h0000_0001, 32'h0000_0500, 0, 5'd0, "R6_miss_not_taken");
      drive(2'b01, 0, 32'h0,       1, 1, 0, 0, 16'h0020, 5'd2, 32'h0000_0001, 32'h0000_0500, 0, 5'd0, "R6_hit_not_taken");
      drive(2'b10, 0, 32'h0,       1, 1, 0, 0, 16'hFFFC, 5'd1, 32'h0,       32'h0000_0800, 0, 5'd0, "R7_back_taken");
      drive(2'b10, 0, 32'h0,       1, 1, 0, 1, 16'h000C, 5'd1, 32'h0,       32'h0000_0800, 0, 5'd0, "R7_fwd_taken");
      drive(2'b10, 0, 32'h0,       1, 1, 0, 0, 16'hFFFC, 5'd1, 32'h0000_0009, 32'h0000_0800, 0, 5'd0, "R7_back_not_taken");
      drive(2'b10, 0, 32'h0,       1, 1, 0, 0, 16'h000C, 5'd1, 32'h0000_0009, 32'h0000_0800, 0, 5'd0, "R7_fwd_not_taken");
      drive(2'b10, 0, 32'h0,       1, 1, 0, 0, 16'hFFFC, 5'd9, 32'h0,       32'h0000_0800, 1, 5'd9, "R8_stall_cancel");
      drive(2'b10, 0, 32'h0,       1, 1, 0, 0, 16'hFFFC, 5'd9, 32'h0,       32'h0000_0800, 0, 5'd9, "R8_after_cancel");
      drive(2'b00, 1, 32'h0000_2000, 1, 1, 0, 0, 16'h0008, 5'd6, 32'h0,     32'h0000_0400, 1, 5'd6, "R9_over_stall");
      drive(2'b00, 1, 32'h0000_3000, 1, 1, 0, 0, 16'h0008, 5'd6, 32'h0,     32'h0000_0400, 0, 5'd0, "R9_over_taken");
      drive(2'b01, 1, 32'h0000_3400, 1, 1, 0, 0, 16'h0008, 5'd6, 32'h0,     32'h0000_0400, 0, 5'd0, "R9_over_cancel");
      drive(2'b00, 0, 32'h0,       0, 1, 0, 0, 16'h0040, 5'd6, 32'h0,       32'h0000_0900, 1, 5'd6, "R10_invalid");
      drive(2'b01, 0, 32'h0,       1, 0, 0, 1, 16'h0040, 5'd6, 32'h0,       32'h0000_0900, 1, 5'd6, "R10_not_branch");
      drive(2'b11, 0, 32'h0,       1, 1, 0, 1, 16'h0002, 5'd8, 32'h0,       32'h0000_0A00, 0, 5'd0, "R5_mode3");
      drive(2'b00, 0, 32'h0,       0, 0, 0, 0, 16'h0000, 5'd0, 32'h0,       32'h0,       0, 5'd0, "R2_tail");
      @(negedge clk);
      @(negedge clk);
      finish_up();
   end
endmodule